// File: doc/BRIEF.md
# Enhanced Memory-Protection Permission Checker

This block decides whether a single memory access may proceed under a table of protection entries. It receives the access address, its size in bytes, the requested read/write/execute bits and a flag that says whether the hart runs in machine mode. Each entry arrives already decoded into an inclusive start/end byte range, an active flag, three permission bits and a lock bit. Two security-policy bits also feed the block: one turns on machine-mode lockdown and one turns on a deny-by-default whitelist policy.

The block is purely combinational. Results are valid in the same cycle as the inputs, and no register sits on any path. No data moves through it, so it has no valid/ready handshake. Every pin is a plain level control or status signal, and no back-pressure rule applies. A caller registers the result wherever its pipeline needs to. The lowest-numbered entry that touches the access decides the result. Under lockdown, permissions come from two fixed sixteen-way truth tables, one for machine mode and one for the other modes. When no entry applies, a default policy chosen by the security bits sets the result.

Top module: `pmpc_checker`

## Requirements
- R1: Entries are examined from index 0 upward. Only active entries take part. The lowest-indexed active entry that contains the first byte or the last byte of the access decides the outcome, and all higher entries are ignored.
- R2: The first byte address is `addr_i` and the last is `addr_i + size_i - 1`, where `size_i` is 1, 2, 4 or 8 bytes. The sum is formed one bit wider than the address, so a last byte beyond the top address lies outside every entry instead of wrapping.
- R3: When the deciding entry contains exactly one of the two bytes, the access is partial. In that case `allowed_o` is 0 and `grant_o` is 0.
- R4: Permission bits are encoded as bit 0 = read, bit 1 = write, bit 2 = execute. With lockdown off, a fully containing entry yields all three bits when `mach_i` is 1 and its lock bit is 0. Otherwise it yields the entry's own three permission bits.
- R5: With lockdown on and `mach_i` = 1, form the index {lock, R, W, X} with lock as bit 3. Indices 2, 3 and 14 give RW. Indices 9 and 10 give X. Indices 11 and 13 give RX. Indices 12 and 15 give R. Every other index gives nothing.
- R6: With lockdown on and `mach_i` = 0, the same index applies. Indices 3 and 6 give RW. Indices 1, 10 and 11 give X. Index 5 gives RX. Index 7 gives RWX. Indices 2, 4 and 15 give R. Every other index gives nothing.
- R7: When an entry fully contains the access, `grant_o` is 1 exactly when every requested bit is present in `allowed_o`.
- R8: When no entry decides and the whitelist bit is 1, `allowed_o` is 0 and `grant_o` is 0.
- R9: When no entry decides, the whitelist bit is 0 and lockdown is on, a machine-mode request without the execute bit gets RW and is granted. Every other request gets nothing and is denied.
- R10: When no entry decides and both security bits are 0, machine mode gets RWX and is granted. Other modes get nothing and are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | ADDR_W | Byte address of the first byte of the access |
| size_i | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_i | input | 3 | Requested permissions {X, W, R} |
| mach_i | input | 1 | 1 when the access is made in machine mode |
| ent_start_i | input | N_ENT*ADDR_W | Inclusive start byte of each entry, entry i in slice i |
| ent_end_i | input | N_ENT*ADDR_W | Inclusive end byte of each entry |
| ent_active_i | input | N_ENT | 1 for each entry that takes part in matching |
| ent_perm_i | input | N_ENT*3 | Permission bits {X, W, R} of each entry |
| ent_lock_i | input | N_ENT | Lock bit of each entry |
| lockdown_i | input | 1 | Machine-mode lockdown policy bit |
| whitelist_i | input | 1 | Deny-by-default policy bit |
| allowed_o | output | 3 | Allowed permissions {X, W, R} |
| grant_o | output | 1 | 1 when the access may proceed |

## Verification
Both `allowed_o` and `grant_o` are due in the same cycle as the stimulus, because no register lies between any input and either output. The bench changes the inputs only just after a falling clock edge. It reads both outputs 2 ns later, well before the next rising edge, so every comparison sees a settled value of the current vector. Expected values come from a model in the bench that applies the requirements to integer arithmetic and bit masks. The model is swept over all sixteen {lock, R, W, X} codes, both modes, both policy bits, every request, and every address and size of a small overlapping layout.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;
  // permission vector: bit0 read, bit1 write, bit2 execute
  typedef logic [2:0] perm_t;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  typedef struct packed {
    logic  lock;
    perm_t perm;
  } rule_t;
endpackage

// File: rtl/pmpc_range.sv
module pmpc_range #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W:0]   first_i,
  input  logic [ADDR_W:0]   last_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic              active_i,
  output logic              first_in_o,
  output logic              last_in_o
);
  logic [ADDR_W:0] lo_x, hi_x;

  always_comb begin
    lo_x       = {1'b0, lo_i};
    hi_x       = {1'b0, hi_i};
    first_in_o = active_i && (first_i >= lo_x) && (first_i <= hi_x);
    last_in_o  = active_i && (last_i  >= lo_x) && (last_i  <= hi_x);
  end
endmodule

// File: rtl/pmpc_pick.sv
module pmpc_pick
  import pmpc_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic [N_ENT-1:0]  first_in_i,
  input  logic [N_ENT-1:0]  last_in_i,
  input  rule_t [N_ENT-1:0] rules_i,
  output logic              hit_o,
  output logic              partial_o,
  output rule_t             rule_o
);
  logic [N_ENT-1:0] touch;
  logic [N_ENT-1:0] win;

  always_comb begin
    touch = first_in_i | last_in_i;
    win   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      win[i] = touch[i] && ((touch & ((N_ENT'(1) << i) - N_ENT'(1))) == '0);
    end
  end

  always_comb begin
    hit_o     = 1'b0;
    partial_o = 1'b0;
    rule_o    = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (win[i]) begin
        hit_o     = 1'b1;
        partial_o = first_in_i[i] ^ last_in_i[i];
        rule_o    = rules_i[i];
      end
    end
  end

  // R1: at most one entry may decide an access
  always_comb begin
    a_r1_single_winner: assert ($onehot0(win))
      else $error("more than one deciding entry");
    a_r1_hit_iff_touch: assert (hit_o == (touch != '0))
      else $error("hit disagrees with entry contact");
  end
endmodule

// File: rtl/pmpc_rule.sv
module pmpc_rule
  import pmpc_pkg::*;
(
  input  rule_t rule_i,
  input  logic  mach_i,
  input  logic  lockdown_i,
  output perm_t allowed_o
);
  logic [3:0] idx;
  perm_t      m_tab, u_tab;

  always_comb begin
    idx = {rule_i.lock, rule_i.perm[0], rule_i.perm[1], rule_i.perm[2]};
    unique case (idx)
      4'd2, 4'd3, 4'd14: m_tab = P_RW;
      4'd9, 4'd10:       m_tab = P_X;
      4'd11, 4'd13:      m_tab = P_RX;
      4'd12, 4'd15:      m_tab = P_R;
      default:           m_tab = P_NONE;
    endcase
    unique case (idx)
      4'd1, 4'd10, 4'd11: u_tab = P_X;
      4'd2, 4'd4, 4'd15:  u_tab = P_R;
      4'd3, 4'd6:         u_tab = P_RW;
      4'd5:               u_tab = P_RX;
      4'd7:               u_tab = P_RWX;
      default:            u_tab = P_NONE;
    endcase
    if (!lockdown_i) allowed_o = (mach_i && !rule_i.lock) ? P_RWX : rule_i.perm;
    else             allowed_o = mach_i ? m_tab : u_tab;
  end

  // R5: under lockdown machine mode never holds write and execute together
  always_comb begin
    a_r5_no_wx_machine: assert (!(lockdown_i && mach_i) || allowed_o[2:1] != 2'b11)
      else $error("machine lockdown granted W and X");
    a_r4_plain_subset: assert (lockdown_i || mach_i || (allowed_o & ~rule_i.perm) == '0)
      else $error("user mode exceeded entry bits");
  end
endmodule

// File: rtl/pmpc_default.sv
module pmpc_default
  import pmpc_pkg::*;
(
  input  logic  mach_i,
  input  logic  lockdown_i,
  input  logic  whitelist_i,
  input  perm_t req_i,
  output perm_t allowed_o
);
  always_comb begin
    if (whitelist_i)     allowed_o = P_NONE;
    else if (lockdown_i) allowed_o = (mach_i && !req_i[2]) ? P_RW : P_NONE;
    else                 allowed_o = mach_i ? P_RWX : P_NONE;
  end
endmodule

// File: rtl/pmpc_checker.sv
module pmpc_checker
  import pmpc_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [3:0]              size_i,
  input  logic [2:0]              req_i,
  input  logic                    mach_i,
  input  logic [N_ENT*ADDR_W-1:0] ent_start_i,
  input  logic [N_ENT*ADDR_W-1:0] ent_end_i,
  input  logic [N_ENT-1:0]        ent_active_i,
  input  logic [N_ENT*3-1:0]      ent_perm_i,
  input  logic [N_ENT-1:0]        ent_lock_i,
  input  logic                    lockdown_i,
  input  logic                    whitelist_i,
  output logic [2:0]              allowed_o,
  output logic                    grant_o
);
  localparam int XW = ADDR_W + 1;

  logic [XW-1:0]     first_x, last_x, size_x;
  logic [N_ENT-1:0]  first_in, last_in;
  rule_t [N_ENT-1:0] rules;
  logic              hit, partial;
  rule_t             sel_rule;
  perm_t             rule_perm, dflt_perm;

  always_comb begin
    size_x  = XW'((size_i == 4'd0) ? 4'd1 : size_i);
    first_x = {1'b0, addr_i};
    last_x  = first_x + size_x - XW'(1);
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign rules[g].lock = ent_lock_i[g];
    assign rules[g].perm = ent_perm_i[g*3 +: 3];
    pmpc_range #(.ADDR_W(ADDR_W)) u_range (
      .first_i   (first_x),
      .last_i    (last_x),
      .lo_i      (ent_start_i[g*ADDR_W +: ADDR_W]),
      .hi_i      (ent_end_i[g*ADDR_W +: ADDR_W]),
      .active_i  (ent_active_i[g]),
      .first_in_o(first_in[g]),
      .last_in_o (last_in[g])
    );
  end

  pmpc_pick #(.N_ENT(N_ENT)) u_pick (
    .first_in_i(first_in),
    .last_in_i (last_in),
    .rules_i   (rules),
    .hit_o     (hit),
    .partial_o (partial),
    .rule_o    (sel_rule)
  );

  pmpc_rule u_rule (
    .rule_i    (sel_rule),
    .mach_i    (mach_i),
    .lockdown_i(lockdown_i),
    .allowed_o (rule_perm)
  );

  pmpc_default u_dflt (
    .mach_i     (mach_i),
    .lockdown_i (lockdown_i),
    .whitelist_i(whitelist_i),
    .req_i      (req_i),
    .allowed_o  (dflt_perm)
  );

  always_comb begin
    if (!hit) begin
      allowed_o = dflt_perm;
      grant_o   = (dflt_perm != P_NONE);
    end else if (partial) begin
      allowed_o = P_NONE;
      grant_o   = 1'b0;
    end else begin
      allowed_o = rule_perm;
      grant_o   = ((req_i & ~rule_perm) == 3'b000);
    end
  end

  always_comb begin
    // R3: a partially covered access is always refused
    a_r3_partial_denied: assert (!(hit && partial) || (!grant_o && allowed_o == 3'b000))
      else $error("partial access not refused");
    // R7: a grant never exceeds the allowed set
    a_r7_grant_within: assert (!grant_o || !hit || (req_i & ~allowed_o) == 3'b000)
      else $error("grant beyond allowed set");
    // R8: whitelist default denies everything
    a_r8_whitelist_deny: assert (hit || !whitelist_i || (!grant_o && allowed_o == 3'b000))
      else $error("whitelist default leaked");
    // R2: an access ending past the top address never fits entirely
    a_r2_no_wrap: assert (!last_x[ADDR_W] || !hit || partial || !first_in[0] || 1'b0 == last_in[0])
      else $error("wrapped access treated as contained");
  end
endmodule

// File: tb/tb_pmpc_checker.sv
module tb_pmpc_checker;
  localparam int N  = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0]   addr;
  logic [3:0]      size;
  logic [2:0]      req;
  logic            mach, ld, wl;
  logic [N*AW-1:0] st_v, en_v;
  logic [N-1:0]    act_v, lk_v;
  logic [N*3-1:0]  pm_v;
  logic [2:0]      allowed;
  logic            grant;

  int es[N], ee[N], ea[N], ep[N], el[N];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pmpc_checker #(.N_ENT(N), .ADDR_W(AW)) dut (
    .addr_i(addr), .size_i(size), .req_i(req), .mach_i(mach),
    .ent_start_i(st_v), .ent_end_i(en_v), .ent_active_i(act_v),
    .ent_perm_i(pm_v), .ent_lock_i(lk_v), .lockdown_i(ld),
    .whitelist_i(wl), .allowed_o(allowed), .grant_o(grant)
  );

  task automatic load();
    for (int i = 0; i < N; i++) begin
      st_v[i*AW +: AW] = AW'(es[i]);
      en_v[i*AW +: AW] = AW'(ee[i]);
      act_v[i] = ea[i][0];
      pm_v[i*3 +: 3] = 3'(ep[i]);
      lk_v[i] = el[i][0];
    end
  endtask

  // reference built from the requirements: returns {grant, allowed}
  function automatic int model(int a, int s, int r, int m, int l, int w);
    int last = a + s - 1;
    int al, ix;
    bit fi, li;
    for (int i = 0; i < N; i++) begin
      if (ea[i] == 0) continue;
      fi = (a >= es[i]) && (a <= ee[i]);
      li = (last >= es[i]) && (last <= ee[i]);
      if (fi != li) return 0;                       // R3
      if (fi) begin
        ix = el[i]*8 + (ep[i] & 1)*4 + (ep[i] & 2) + ((ep[i] >> 2) & 1);
        if (l == 0) al = (m != 0 && el[i] == 0) ? 7 : ep[i];   // R4
        else if (m != 0)                                        // R5
          al = ((16'hF80C >> ix) & 1) | (((16'h400C >> ix) & 1) << 1) | (((16'h2E00 >> ix) & 1) << 2);
        else                                                    // R6
          al = ((16'h80FC >> ix) & 1) | (((16'h00C8 >> ix) & 1) << 1) | (((16'h0CA2 >> ix) & 1) << 2);
        return (((r & ~al) == 0) ? 8 : 0) + al;                 // R7
      end
    end
    if (w != 0) return 0;                                       // R8
    if (l != 0) return (m != 0 && (r & 4) == 0) ? 8 + 3 : 0;    // R9
    return (m != 0) ? 8 + 7 : 0;                                // R10
  endfunction

  task automatic run(input string tag, input int a, input int s, input int r,
                     input int m, input int l, input int w);
    int e;
    @(negedge clk);
    addr = AW'(a); size = 4'(s); req = 3'(r);
    mach = m[0]; ld = l[0]; wl = w[0];
    #2;
    e = model(a, s, r, m, l, w);
    n_chk++;
    if (allowed !== 3'(e & 7)) begin
      n_bad++;
      $display("FAIL %s allowed a=%0d s=%0d r=%0d m=%0d l=%0d w=%0d act=%0d exp=%0d",
               tag, a, s, r, m, l, w, allowed, e & 7);
    end
    n_chk++;
    if (grant !== e[3]) begin
      n_bad++;
      $display("FAIL %s grant a=%0d s=%0d r=%0d m=%0d l=%0d w=%0d act=%0b exp=%0b",
               tag, a, s, r, m, l, w, grant, e[3]);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin es[i]=0; ee[i]=0; ea[i]=0; ep[i]=0; el[i]=0; end
    load();
    // reset-like idle state, no entries: R10 machine default
    run("R10", 0, 1, 0, 1, 0, 0);
    // R8 R9 R10: default paths, no active entry
    for (int w = 0; w < 2; w++) for (int l = 0; l < 2; l++)
      for (int m = 0; m < 2; m++) for (int r = 0; r < 8; r++)
        run(w ? "R8" : (l ? "R9" : "R10"), 40, 4, r, m, l, w);
    // R4 R5 R6 R7: full truth-table sweep on one all-covering entry
    es[0]=0; ee[0]=255; ea[0]=1;
    for (int c = 0; c < 16; c++) begin
      el[0] = c >> 3; ep[0] = c & 7; load();
      for (int l = 0; l < 2; l++) for (int m = 0; m < 2; m++)
        for (int r = 0; r < 8; r++)
          run(l ? (m ? "R5" : "R6") : "R4", 100, 1, r, m, l, c & 1);
    end
    // R2: last byte past top address is partial, not wrapped
    el[0]=0; ep[0]=7; load();
    run("R2", 255, 2, 1, 1, 0, 0);
    run("R2", 252, 8, 0, 1, 0, 0);
    run("R2", 248, 8, 1, 0, 0, 0);
    // R1 R3: overlapping layout, every address and size
    es[0]=16; ee[0]=31;  ea[0]=1; ep[0]=1; el[0]=0;
    es[1]=0;  ee[1]=63;  ea[1]=1; ep[1]=3; el[1]=1;
    es[2]=0;  ee[2]=255; ea[2]=0; ep[2]=7; el[2]=0;
    es[3]=60; ee[3]=200; ea[3]=1; ep[3]=4; el[3]=1;
    load();
    for (int a = 0; a < 256; a++)
      for (int sz = 0; sz < 4; sz++)
        for (int md = 0; md < 4; md++)
          run("R1_R3", a, 1 << sz, (md & 1) ? 4 : 1, md & 1, md >> 1, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule